// File: doc/BRIEF.md
# Priority-Bid Interrupt Arbiter for a Two-Channel UART

This block decides which interrupt source of a two-channel UART is presented to the host. Every source forms a 12-bit numeric bid. The low bit identifies the channel or unit. The next four bits hold a type code unique to the kind of source. The top seven bits hold a magnitude. For receivers that magnitude is the live receive FIFO fill count. For transmitters it is the free-slot count of the transmit FIFO. For every other source it is a field programmed by software. Because the fill count is part of the bid, a receiver's priority rises as its FIFO fills.

A combinational maximum picks the highest active bid every cycle. A two-state machine then registers the result. In state WATCH the outputs follow the current best bid, and the interrupt request is raised when the best bid, ignoring its channel bit, is strictly greater than an 11-bit threshold. That edge is the transition WATCH→HOLD. In state HOLD the reported bid and type code are frozen. HOLD exits through the transition HOLD→WATCH when the host acknowledges or the winning source goes inactive. On that edge the request drops for one cycle and the outputs load the bid that wins at that moment. Receivers and transmitters do not bid until their per-channel trigger level is met, and each channel selects that level independently.

Top module: `prio_irq_arb`

## Requirements
- R1: The bid layout is {magnitude[11:5], type[4:1], unit[0]}. `win_type_o` always equals bits 4:1 of `win_bid_o`. Type codes: receive ok 0001, receive error 0101, receive watchdog 0100, transmit 0010, break change 1110, loopback error 1111, port change 0110, flow-control event 0111, address match 1011, timer 1000. The unit bit is 0 for channel A or unit 0, and 1 for channel B or unit 1.
- R2: A receiver uses code 0101 when its error flag is set, else 0100 when its watchdog flag is set, else 0001. A pending watchdog makes the receiver bid even when the fill count is below the trigger level.
- R3: A receiver bids when its fill count is at least the level chosen by its 2-bit select: 0 → 1, 1 → DEPTH/2, 2 → (3·DEPTH)/4, 3 → DEPTH. With DEPTH=64 these are 1, 32, 48 and 64.
- R4: A transmitter bids when its free-slot count meets the same four levels under its own 2-bit select, and its magnitude is the free-slot count.
- R5: The magnitude of a receiver bid is its fill count. For break change, loopback error, flow-control event, address match, port change and timer sources, the magnitude is the programmed field. A larger magnitude beats any type code.
- R6: The highest full 12-bit bid wins. When two bids are otherwise equal, the unit bit decides and channel B (1) beats channel A (0).
- R7: The request is raised only when bits 11:1 of the best bid are strictly greater than `thresh_i`. An equal value does not raise it, and the unit bit is never compared.
- R8: With no source active, the reported bid and type are zero and the request is low.
- R9: While the request is high, the reported bid and type stay unchanged, even if a higher bid appears.
- R10: An acknowledge while the request is high, or the winning source going inactive, drops the request for one cycle and loads the currently winning bid. On the next cycle the threshold test is made again.
- R11: Reset clears the request, the bid and the type, and places the block in state WATCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_i | input | 1 | Host acknowledge of the current request |
| rx_cnt_i | input | 2×7 | Receive FIFO fill count per channel |
| rx_lvl_i | input | 2×2 | Receive trigger-level select per channel |
| rx_err_i | input | 2 | Receive FIFO holds an errored character, per channel |
| rx_wd_i | input | 2 | Receive watchdog timeout pending, per channel |
| tx_free_i | input | 2×7 | Transmit FIFO free-slot count per channel |
| tx_lvl_i | input | 2×2 | Transmit trigger-level select per channel |
| brk_evt_i | input | 2 | Break-change event per channel |
| brk_fld_i | input | 2×7 | Programmed magnitude, break change |
| lpb_evt_i | input | 2 | Loopback-error event per channel |
| lpb_fld_i | input | 2×7 | Programmed magnitude, loopback error |
| xon_evt_i | input | 2 | Flow-control character event per channel |
| xon_fld_i | input | 2×7 | Programmed magnitude, flow-control event |
| adr_evt_i | input | 2 | Address-match event per channel |
| adr_fld_i | input | 2×7 | Programmed magnitude, address match |
| cos_evt_i | input | 2 | Port change-of-state event per unit |
| cos_fld_i | input | 2×7 | Programmed magnitude, port change |
| tmr_evt_i | input | 2 | Counter/timer event per unit |
| tmr_fld_i | input | 2×7 | Programmed magnitude, timer |
| thresh_i | input | 11 | Threshold compared against bid bits 11:1 |
| irq_o | output | 1 | Host interrupt request |
| win_bid_o | output | 12 | Reported winning bid |
| win_type_o | output | 4 | Type code of the reported bid |

## Verification
The block's two functions that can fall on the same edge are releasing a held winner and electing a new one. This happens when an acknowledge arrives in the same cycle that a higher bid appears, or when the winning source clears while another source is still active. The bench holds a receiver winner, raises a stronger receiver on the other channel, and then pulses the acknowledge. It judges that the request drops for exactly one cycle while the new bid is loaded, and that the request is raised again one cycle later. Removing the winner instead must give the same one-cycle gap, and the survivor must become the new winner.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NCH    = 2;
    localparam int NUNIT  = 2;
    localparam int PER_CH = 6;
    localparam int NSRC   = PER_CH * NCH + 2 * NUNIT;

    // source type codes (bid bits 4:1)
    localparam logic [3:0] C_RX_OK  = 4'b0001;
    localparam logic [3:0] C_RX_ERR = 4'b0101;
    localparam logic [3:0] C_RX_WD  = 4'b0100;
    localparam logic [3:0] C_TX     = 4'b0010;
    localparam logic [3:0] C_BRK    = 4'b1110;
    localparam logic [3:0] C_LPB    = 4'b1111;
    localparam logic [3:0] C_COS    = 4'b0110;
    localparam logic [3:0] C_XON    = 4'b0111;
    localparam logic [3:0] C_ADR    = 4'b1011;
    localparam logic [3:0] C_TMR    = 4'b1000;

    typedef enum logic {
        ST_WATCH,
        ST_HOLD
    } arb_state_e;
endpackage

// File: rtl/prio_irq_lvl.sv
module prio_irq_lvl #(
    parameter int CNT_W = 7,
    parameter int DEPTH = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       sel_i,
    output logic             met_o
);
    localparam int L_HALF = DEPTH / 2;
    localparam int L_3Q   = (3 * DEPTH) / 4;

    logic [CNT_W-1:0] mark;

    always_comb begin
        case (sel_i)
            2'd0:    mark = CNT_W'(1);
            2'd1:    mark = CNT_W'(L_HALF);
            2'd2:    mark = CNT_W'(L_3Q);
            default: mark = CNT_W'(DEPTH);
        endcase
    end

    assign met_o = (cnt_i >= mark);
endmodule

// File: rtl/prio_irq_bids.sv
module prio_irq_bids
    import prio_irq_pkg::*;
#(
    parameter int BID_W = 12,
    parameter int DEPTH = 64,
    localparam int FLD_W = BID_W - 5
) (
    input  logic [NCH-1:0][FLD_W-1:0]   rx_cnt_i,
    input  logic [NCH-1:0][1:0]         rx_lvl_i,
    input  logic [NCH-1:0]              rx_err_i,
    input  logic [NCH-1:0]              rx_wd_i,
    input  logic [NCH-1:0][FLD_W-1:0]   tx_free_i,
    input  logic [NCH-1:0][1:0]         tx_lvl_i,
    input  logic [NCH-1:0]              brk_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   brk_fld_i,
    input  logic [NCH-1:0]              lpb_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   lpb_fld_i,
    input  logic [NCH-1:0]              xon_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   xon_fld_i,
    input  logic [NCH-1:0]              adr_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   adr_fld_i,
    input  logic [NUNIT-1:0]            cos_evt_i,
    input  logic [NUNIT-1:0][FLD_W-1:0] cos_fld_i,
    input  logic [NUNIT-1:0]            tmr_evt_i,
    input  logic [NUNIT-1:0][FLD_W-1:0] tmr_fld_i,
    output logic [NSRC-1:0]             act_o,
    output logic [NSRC-1:0][BID_W-1:0]  bids_o
);
    logic [NSRC-1:0][BID_W-1:0] raw;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int   BASE = ch * PER_CH;
        localparam logic UNIT = 1'(ch);
        logic       rx_met;
        logic       tx_met;
        logic [3:0] rx_code;

        prio_irq_lvl #(.CNT_W(FLD_W), .DEPTH(DEPTH)) u_rx_lvl (
            .cnt_i (rx_cnt_i[ch]),
            .sel_i (rx_lvl_i[ch]),
            .met_o (rx_met)
        );
        prio_irq_lvl #(.CNT_W(FLD_W), .DEPTH(DEPTH)) u_tx_lvl (
            .cnt_i (tx_free_i[ch]),
            .sel_i (tx_lvl_i[ch]),
            .met_o (tx_met)
        );

        // error outranks watchdog, watchdog outranks plain data
        assign rx_code = rx_err_i[ch] ? C_RX_ERR : (rx_wd_i[ch] ? C_RX_WD : C_RX_OK);

        assign act_o[BASE+0] = rx_met | rx_wd_i[ch];
        assign raw[BASE+0]   = {rx_cnt_i[ch], rx_code, UNIT};
        assign act_o[BASE+1] = tx_met;
        assign raw[BASE+1]   = {tx_free_i[ch], C_TX, UNIT};
        assign act_o[BASE+2] = brk_evt_i[ch];
        assign raw[BASE+2]   = {brk_fld_i[ch], C_BRK, UNIT};
        assign act_o[BASE+3] = lpb_evt_i[ch];
        assign raw[BASE+3]   = {lpb_fld_i[ch], C_LPB, UNIT};
        assign act_o[BASE+4] = xon_evt_i[ch];
        assign raw[BASE+4]   = {xon_fld_i[ch], C_XON, UNIT};
        assign act_o[BASE+5] = adr_evt_i[ch];
        assign raw[BASE+5]   = {adr_fld_i[ch], C_ADR, UNIT};
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        localparam int   COS_IDX = PER_CH * NCH + u;
        localparam int   TMR_IDX = PER_CH * NCH + NUNIT + u;
        localparam logic UNIT    = 1'(u);
        assign act_o[COS_IDX] = cos_evt_i[u];
        assign raw[COS_IDX]   = {cos_fld_i[u], C_COS, UNIT};
        assign act_o[TMR_IDX] = tmr_evt_i[u];
        assign raw[TMR_IDX]   = {tmr_fld_i[u], C_TMR, UNIT};
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign bids_o[i] = act_o[i] ? raw[i] : '0;
    end
endmodule

// File: rtl/prio_irq_max.sv
module prio_irq_max #(
    parameter int BID_W = 12,
    parameter int NSRC  = 16,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0][BID_W-1:0] bids_i,
    output logic [BID_W-1:0]           best_o,
    output logic [IDX_W-1:0]           idx_o
);
    always_comb begin
        best_o = '0;
        idx_o  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bids_i[i] > best_o) begin
                best_o = bids_i[i];
                idx_o  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int BID_W = 12,
    parameter int DEPTH = 64,
    localparam int FLD_W = BID_W - 5,
    localparam int THR_W = BID_W - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ack_i,
    input  logic [NCH-1:0][FLD_W-1:0]   rx_cnt_i,
    input  logic [NCH-1:0][1:0]         rx_lvl_i,
    input  logic [NCH-1:0]              rx_err_i,
    input  logic [NCH-1:0]              rx_wd_i,
    input  logic [NCH-1:0][FLD_W-1:0]   tx_free_i,
    input  logic [NCH-1:0][1:0]         tx_lvl_i,
    input  logic [NCH-1:0]              brk_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   brk_fld_i,
    input  logic [NCH-1:0]              lpb_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   lpb_fld_i,
    input  logic [NCH-1:0]              xon_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   xon_fld_i,
    input  logic [NCH-1:0]              adr_evt_i,
    input  logic [NCH-1:0][FLD_W-1:0]   adr_fld_i,
    input  logic [NUNIT-1:0]            cos_evt_i,
    input  logic [NUNIT-1:0][FLD_W-1:0] cos_fld_i,
    input  logic [NUNIT-1:0]            tmr_evt_i,
    input  logic [NUNIT-1:0][FLD_W-1:0] tmr_fld_i,
    input  logic [THR_W-1:0]            thresh_i,
    output logic                        irq_o,
    output logic [BID_W-1:0]            win_bid_o,
    output logic [3:0]                  win_type_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]            act;
    logic [NSRC-1:0][BID_W-1:0] bids;
    logic [BID_W-1:0]           best;
    logic [IDX_W-1:0]           best_idx;
    logic                       above;
    logic                       release_hold;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] widx_q;

    prio_irq_bids #(.BID_W(BID_W), .DEPTH(DEPTH)) u_bids (
        .rx_cnt_i  (rx_cnt_i),
        .rx_lvl_i  (rx_lvl_i),
        .rx_err_i  (rx_err_i),
        .rx_wd_i   (rx_wd_i),
        .tx_free_i (tx_free_i),
        .tx_lvl_i  (tx_lvl_i),
        .brk_evt_i (brk_evt_i),
        .brk_fld_i (brk_fld_i),
        .lpb_evt_i (lpb_evt_i),
        .lpb_fld_i (lpb_fld_i),
        .xon_evt_i (xon_evt_i),
        .xon_fld_i (xon_fld_i),
        .adr_evt_i (adr_evt_i),
        .adr_fld_i (adr_fld_i),
        .cos_evt_i (cos_evt_i),
        .cos_fld_i (cos_fld_i),
        .tmr_evt_i (tmr_evt_i),
        .tmr_fld_i (tmr_fld_i),
        .act_o     (act),
        .bids_o    (bids)
    );

    prio_irq_max #(.BID_W(BID_W), .NSRC(NSRC)) u_max (
        .bids_i (bids),
        .best_o (best),
        .idx_o  (best_idx)
    );

    // channel bit (bit 0) is left out of the threshold compare
    assign above        = (best[BID_W-1:1] > thresh_i);
    assign release_hold = ack_i | ~act[widx_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (above)        state_d = ST_HOLD;
            ST_HOLD:  if (release_hold) state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            win_bid_o  <= '0;
            win_type_o <= '0;
            widx_q     <= '0;
        end else begin
            unique case (state_q)
                ST_WATCH: begin
                    win_bid_o  <= best;
                    win_type_o <= best[4:1];
                    widx_q     <= best_idx;
                    irq_o      <= above;
                end
                ST_HOLD: begin
                    if (release_hold) begin
                        win_bid_o  <= best;
                        win_type_o <= best[4:1];
                        widx_q     <= best_idx;
                        irq_o      <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int BID_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic [BID_W-2:0] thresh_i,
    input logic             irq_o,
    input logic [BID_W-1:0] win_bid_o,
    input logic [3:0]       win_type_o
);
    p_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (win_bid_o[BID_W-1:1] > $past(thresh_i)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> ($stable(win_bid_o) && $stable(win_type_o)));

    p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_bid_o == '0) |-> (!irq_o && win_type_o == 4'd0));
endmodule

bind prio_irq_arb prio_irq_chk #(.BID_W(BID_W)) u_prio_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .thresh_i   (thresh_i),
    .irq_o      (irq_o),
    .win_bid_o  (win_bid_o),
    .win_type_o (win_type_o)
);

// File: tb/test_prio_irq_arb.sv
`timescale 1ns/1ps
module test_prio_irq_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_i = 1'b0;
    logic [1:0][6:0] rx_cnt_i = '0, tx_free_i = '0;
    logic [1:0][1:0] rx_lvl_i = '0, tx_lvl_i = '0;
    logic [1:0] rx_err_i = '0, rx_wd_i = '0;
    logic [1:0] brk_evt_i = '0, lpb_evt_i = '0, xon_evt_i = '0, adr_evt_i = '0;
    logic [1:0] cos_evt_i = '0, tmr_evt_i = '0;
    logic [1:0][6:0] brk_fld_i = '0, lpb_fld_i = '0, xon_fld_i = '0, adr_fld_i = '0;
    logic [1:0][6:0] cos_fld_i = '0, tmr_fld_i = '0;
    logic [10:0] thresh_i = '0;
    logic        irq_o;
    logic [11:0] win_bid_o;
    logic [3:0]  win_type_o;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_arb i_prio_irq_arb (.*);

    typedef struct packed {
        logic [6:0]  rxa;
        logic [6:0]  rxb;
        logic [3:0]  rlv;
        logic [1:0]  rerr;
        logic [1:0]  rwd;
        logic [6:0]  txa;
        logic [6:0]  txb;
        logic [3:0]  tlv;
        logic [11:0] ev;
        logic [6:0]  fld;
        logic [10:0] thr;
        logic [11:0] ebid;
        logic        eirq;
        logic [3:0]  rq;
    } vec_t;

    // ev bits: brk 1:0, lpb 3:2, xon 5:4, adr 7:6, cos 9:8, tmr 11:10
    localparam vec_t VECS [19] = '{
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h000, 1'b0, 4'd8},   // R8
        '{7'd5, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h0A2, 1'b1, 4'd1},   // R1
        '{7'd5, 7'd5, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h0A3, 1'b1, 4'd6},   // R6 tie
        '{7'd20,7'd0, 4'h1, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h000, 1'b0, 4'd3},   // R3 below half
        '{7'd32,7'd0, 4'h1, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h402, 1'b1, 4'd3},   // R3 half
        '{7'd47,7'd48,4'hA, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h603, 1'b1, 4'd3},   // R3 3/4
        '{7'd63,7'd64,4'hF, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h803, 1'b1, 4'd3},   // R3 full
        '{7'd3, 7'd0, 4'h0, 2'b01, 2'b00, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h06A, 1'b1, 4'd2},   // R2 error
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b01, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h008, 1'b1, 4'd2},   // R2 watchdog
        '{7'd2, 7'd0, 4'h0, 2'b01, 2'b01, 7'd0, 7'd0, 4'h0, 12'h000, 7'd0, 11'd0, 12'h04A, 1'b1, 4'd2},   // R2 precedence
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd64,7'd0, 4'h3, 12'h000, 7'd0, 11'd0, 12'h804, 1'b1, 4'd4},   // R4 empty
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd47,7'd1, 4'h2, 12'h000, 7'd0, 11'd0, 12'h025, 1'b1, 4'd4},   // R4 not full
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'hFFF, 7'd3, 11'd0, 12'h07F, 1'b1, 4'd5},   // R5 all fields
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h010, 7'd2, 11'd39,12'h04E, 1'b0, 4'd7},   // R7 equal
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h010, 7'd2, 11'd38,12'h04E, 1'b1, 4'd7},   // R7 above
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h020, 7'd2, 11'd39,12'h04F, 1'b0, 4'd7},   // R7 unit bit
        '{7'd4, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h002, 7'd3, 11'd0, 12'h082, 1'b1, 4'd5},   // R5 count beats code
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'hA00, 7'd1, 11'd0, 12'h031, 1'b1, 4'd6},   // R6 timer over port
        '{7'd0, 7'd0, 4'h0, 2'b00, 2'b00, 7'd0, 7'd0, 4'h0, 12'h040, 7'd0, 11'd11,12'h016, 1'b0, 4'd7}    // R7 address match
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(vec_t v, logic ack);
        rx_cnt_i[0] = v.rxa;  rx_cnt_i[1] = v.rxb;
        rx_lvl_i[0] = v.rlv[1:0]; rx_lvl_i[1] = v.rlv[3:2];
        rx_err_i = v.rerr;    rx_wd_i = v.rwd;
        tx_free_i[0] = v.txa; tx_free_i[1] = v.txb;
        tx_lvl_i[0] = v.tlv[1:0]; tx_lvl_i[1] = v.tlv[3:2];
        brk_evt_i = v.ev[1:0];  lpb_evt_i = v.ev[3:2];
        xon_evt_i = v.ev[5:4];  adr_evt_i = v.ev[7:6];
        cos_evt_i = v.ev[9:8];  tmr_evt_i = v.ev[11:10];
        for (int k = 0; k < 2; k++) begin
            brk_fld_i[k] = v.fld; lpb_fld_i[k] = v.fld; xon_fld_i[k] = v.fld;
            adr_fld_i[k] = v.fld; cos_fld_i[k] = v.fld; tmr_fld_i[k] = v.fld;
        end
        thresh_i = v.thr;
        ack_i = ack;
    endtask

    task automatic check(string tag, logic [11:0] ebid, logic eirq);
        total++;
        if (win_bid_o !== ebid || win_type_o !== ebid[4:1] || irq_o !== eirq) begin
            bad++;
            $display("FAIL %s: bid=%h type=%h irq=%b expected bid=%h type=%h irq=%b",
                     tag, win_bid_o, win_type_o, irq_o, ebid, ebid[4:1], eirq);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t z;
        z = '0;
        repeat (3) @(negedge clk);
        check("R11 reset", 12'h000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            apply(VECS[i], 1'b1);
            tick();
            ack_i = 1'b0;
            tick();
            check($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].ebid, VECS[i].eirq);
        end

        // R9: hold while a higher bid appears
        apply(z, 1'b1);
        tick();
        ack_i = 1'b0;
        tick();
        rx_cnt_i[0] = 7'd5;
        tick();
        check("R9 latch", 12'h0A2, 1'b1);
        rx_cnt_i[1] = 7'd10;
        tick();
        check("R9 hold", 12'h0A2, 1'b1);
        // R10: acknowledge releases and loads the new winner in the same edge
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        check("R10 ack gap", 12'h143, 1'b0);
        tick();
        check("R10 re-elect", 12'h143, 1'b1);
        // R10: winner drops out
        rx_cnt_i[1] = 7'd0;
        tick();
        check("R10 clear gap", 12'h0A2, 1'b0);
        tick();
        check("R10 survivor", 12'h0A2, 1'b1);
        // R11: reset in the middle of a hold
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset", 12'h000, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule